// File: doc/BRIEF.md
# Weighted Moment Accumulator for Circle and Line Fits

This block gathers, one point per cycle, the weighted sums that a least-squares fit needs. In circle mode it collects the moments used to fit x²+y²+ax+by+c=0 to transverse hit positions. In line mode it collects the moments used to fit Φ+kz+Φ0=0 to longitudinal points. Every point carries two signed coordinates (u, v) and a quantised drift distance d. Each point enters every sum with a weight of 1/d², which a small reciprocal table supplies.

A track begins with a start pulse. The pulse clears all sums and latches the fit mode. Points follow with a valid flag, and the final point of the track carries a last flag. One cycle after that point, a done strobe marks the sums as complete. A downstream solver reads the sums while they hold, until the next start. The solver works out the fit parameters from them, and can run the same track through the block again for a second iteration.

Top module: `wlsq_moment_acc`

## Requirements
- R1: After reset, done_o is 0 and all ten sums are 0.
- R2: A start pulse clears every sum and latches mode_i as the track mode (0 selects circle, 1 selects line). A point presented in the same cycle as start is the first point of the new track.
- R3: The weight is floor(256 / d²) for drift code d in 1..15, and d = 0 is treated as d = 1 (weight 256). It appears alone in sum index 0.
- R4: In circle mode, sums_o slot k holds Σw·m_k. The monomials m_k, indexed from 0 to 9, are: 1, u, v, u², u·v, v², u³, u²·v, u·v², v³. The coordinates u = x and v = y are 8-bit two's complement.
- R5: In line mode, slots 0 to 5 accumulate as in R4 with u = z and v = Φ, and slots 6 to 9 stay 0.
- R6: done_o is high for exactly the one cycle after the cycle in which a point flagged last is accepted. The sums are then final and hold until the next start.
- R7: A valid point that arrives after a track's last point and before the next start is ignored. The sums do not change and done_o stays 0.
- R8: Changing mode_i during a track has no effect on that track.
- R9: A track of 64 points, all at u = v = −128 and d = 0, produces exact sums with no wrap. For example, slot 6 reads −34359738368.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a track: clear sums, latch mode |
| mode_i | input | 1 | Fit mode sampled at start: 0 circle, 1 line |
| pt_valid_i | input | 1 | A point is presented this cycle |
| pt_last_i | input | 1 | The presented point ends the track |
| pt_u_i | input | CW (8) | First coordinate, signed (x or z) |
| pt_v_i | input | CW (8) | Second coordinate, signed (y or Φ) |
| pt_d_i | input | DW (4) | Quantised drift distance |
| done_o | output | 1 | One-cycle strobe: sums complete |
| sums_o | output | 10×ACCW (10×37) | Packed weighted sums, slot k in bits [k*ACCW +: ACCW] |

## Verification
The properties assume that start, valid and last are sampled once per clock edge as single-cycle qualifiers. They also assume that no track exceeds the 64-point depth the accumulator width was sized for. The exact-sum checks rely on that second assumption. Every directed track in the stimulus stays at or under 64 points. The widest case is the 64-point full-scale track. The stimulus also presents stray points only through the normal valid input, never by forcing internal state.

// File: rtl/wlsq_pkg.sv
package wlsq_pkg;
  localparam int NMOM = 10;

  // Slot order of the packed sums: decoded by the downstream solver.
  typedef enum logic [3:0] {
    M_W = 4'd0, M_U, M_V, M_UU, M_UV, M_VV, M_UUU, M_UUV, M_UVV, M_VVV
  } mom_e;

  typedef enum logic {FIT_CIRCLE = 1'b0, FIT_LINE = 1'b1} fit_mode_e;

  // floor(2^wb / d^2), a zero drift code is clamped to one.
  function automatic int unsigned recip_sq(int unsigned d, int unsigned wb);
    int unsigned dd;
    dd = (d == 0) ? 1 : d;
    return (32'd1 << wb) / (dd * dd);
  endfunction
endpackage

// File: rtl/wlsq_weight_lut.sv
module wlsq_weight_lut #(
  parameter int DW = 4,
  parameter int WB = 8,
  localparam int WW = WB + 1,
  localparam int NENT = 1 << DW
) (
  input  logic [DW-1:0] d_i,
  output logic [WW-1:0] w_o
);
  logic [WW-1:0] tbl [NENT];

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    assign tbl[i] = WW'(wlsq_pkg::recip_sq(i, WB));
  end

  assign w_o = tbl[d_i];
endmodule

// File: rtl/wlsq_monomials.sv
module wlsq_monomials
  import wlsq_pkg::*;
#(
  parameter int CW   = 8,
  parameter int WW   = 9,
  parameter int ACCW = 37
) (
  input  logic signed [CW-1:0]     u_i,
  input  logic signed [CW-1:0]     v_i,
  input  logic [WW-1:0]            w_i,
  input  logic                     third_en_i,
  output logic [NMOM-1:0][ACCW-1:0] term_o
);
  logic signed [ACCW-1:0] u_x, v_x, w_x, wu, wv, wuu, wuv, wvv;

  always_comb begin
    u_x = {{(ACCW-CW){u_i[CW-1]}}, u_i};
    v_x = {{(ACCW-CW){v_i[CW-1]}}, v_i};
    w_x = {{(ACCW-WW){1'b0}}, w_i};
    wu  = w_x * u_x;
    wv  = w_x * v_x;
    wuu = wu * u_x;
    wuv = wu * v_x;
    wvv = wv * v_x;
    term_o        = '0;
    term_o[M_W]   = w_x;
    term_o[M_U]   = wu;
    term_o[M_V]   = wv;
    term_o[M_UU]  = wuu;
    term_o[M_UV]  = wuv;
    term_o[M_VV]  = wvv;
    if (third_en_i) begin
      term_o[M_UUU] = wuu * u_x;
      term_o[M_UUV] = wuu * v_x;
      term_o[M_UVV] = wvv * u_x;
      term_o[M_VVV] = wvv * v_x;
    end
  end
endmodule

// File: rtl/wlsq_accum.sv
module wlsq_accum
  import wlsq_pkg::*;
#(
  parameter int ACCW = 37
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      add_i,
  input  logic [NMOM-1:0][ACCW-1:0] term_i,
  output logic [NMOM-1:0][ACCW-1:0] sum_o
);
  for (genvar k = 0; k < NMOM; k++) begin : g_acc
    logic [ACCW-1:0] acc_q, acc_d;
    logic            acc_en;

    always_comb begin
      acc_en = clr_i | add_i;
      if (clr_i) acc_d = add_i ? term_i[k] : '0;
      else       acc_d = acc_q + term_i[k];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     acc_q <= '0;
      else if (acc_en) acc_q <= acc_d;
    end

    assign sum_o[k] = acc_q;
  end
endmodule

// File: rtl/wlsq_moment_acc.sv
module wlsq_moment_acc
  import wlsq_pkg::*;
#(
  parameter int CW     = 8,
  parameter int DW     = 4,
  parameter int WB     = 8,
  parameter int MAXPTS = 64,
  parameter int ACCW   = 3 * (CW - 1) + WB + 2 + $clog2(MAXPTS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      mode_i,
  input  logic                      pt_valid_i,
  input  logic                      pt_last_i,
  input  logic signed [CW-1:0]      pt_u_i,
  input  logic signed [CW-1:0]      pt_v_i,
  input  logic [DW-1:0]             pt_d_i,
  output logic                      done_o,
  output logic [NMOM-1:0][ACCW-1:0] sums_o
);
  localparam int WW = WB + 1;

  // reset: asserts at once, releases after two clock edges
  logic rst_meta, rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // track control
  logic open_q, open_d, mode_q, mode_d, done_q, done_d;
  logic accept, eff_mode;

  always_comb begin
    accept   = pt_valid_i & (open_q | start_i);
    eff_mode = start_i ? mode_i : mode_q;
    mode_d   = eff_mode;
    done_d   = accept & pt_last_i;
    if (start_i) open_d = ~done_d;
    else         open_d = open_q & ~done_d;
  end

  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q) begin
      open_q <= 1'b0;
      mode_q <= FIT_CIRCLE;
      done_q <= 1'b0;
    end else begin
      open_q <= open_d;
      done_q <= done_d;
      if (start_i) mode_q <= mode_d;
    end
  end

  logic [WW-1:0]             weight;
  logic [NMOM-1:0][ACCW-1:0] terms;

  wlsq_weight_lut #(.DW(DW), .WB(WB)) u_lut (
    .d_i (pt_d_i),
    .w_o (weight)
  );

  wlsq_monomials #(.CW(CW), .WW(WW), .ACCW(ACCW)) u_mono (
    .u_i        (pt_u_i),
    .v_i        (pt_v_i),
    .w_i        (weight),
    .third_en_i (eff_mode == FIT_CIRCLE),
    .term_o     (terms)
  );

  wlsq_accum #(.ACCW(ACCW)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_q),
    .clr_i  (start_i),
    .add_i  (accept),
    .term_i (terms),
    .sum_o  (sums_o)
  );

  assign done_o = done_q;
endmodule

// File: rtl/wlsq_moment_acc_chk.sv
module wlsq_moment_acc_chk
  import wlsq_pkg::*;
#(
  parameter int ACCW = 37
) (
  input logic                      clk_i,
  input logic                      rst_q,
  input logic                      start_i,
  input logic                      pt_valid_i,
  input logic                      pt_last_i,
  input logic                      open_q,
  input logic                      mode_q,
  input logic                      done_o,
  input logic [NMOM-1:0][ACCW-1:0] sums_o
);
  // R6: a done strobe is always caused by an accepted last point
  a_r6_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_q)
    done_o |-> $past(pt_valid_i && pt_last_i && (open_q || start_i)));

  // R2: start without a point leaves all sums at zero
  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_q)
    (start_i && !pt_valid_i) |=> (sums_o == '0));

  // R7: with nothing accepted and no start the sums hold
  a_r7_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_q)
    (!start_i && !(pt_valid_i && open_q)) |=> $stable(sums_o));

  // R5: a line track never builds third-order sums
  a_r5_line_third_zero: assert property (@(posedge clk_i) disable iff (!rst_q)
    (mode_q == FIT_LINE) |-> (sums_o[M_UUU] == '0 && sums_o[M_UUV] == '0 &&
                              sums_o[M_UVV] == '0 && sums_o[M_VVV] == '0));

  // R3: every accepted point adds a weight of at least one
  a_r3_weight_grows: assert property (@(posedge clk_i) disable iff (!rst_q)
    (pt_valid_i && open_q && !start_i) |=> (sums_o[M_W] > $past(sums_o[M_W])));
endmodule

bind wlsq_moment_acc wlsq_moment_acc_chk #(.ACCW(ACCW)) u_chk (
  .clk_i      (clk_i),
  .rst_q      (rst_q),
  .start_i    (start_i),
  .pt_valid_i (pt_valid_i),
  .pt_last_i  (pt_last_i),
  .open_q     (open_q),
  .mode_q     (mode_q),
  .done_o     (done_o),
  .sums_o     (sums_o)
);

// File: tb/sim_wlsq_moment_acc.sv
`timescale 1ns/1ps
module sim_wlsq_moment_acc;
  localparam int ACCW = 37;
  localparam int NM   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0, pvld = 1'b0, plast = 1'b0;
  logic signed [7:0] pu = '0, pv = '0;
  logic [3:0] pd = '0;
  logic done;
  logic [NM-1:0][ACCW-1:0] sums;

  int tests = 0, fails = 0;
  longint rexp [NM];
  logic bopen = 1'b0, bmode = 1'b0;

  always #2 clk = ~clk;

  wlsq_moment_acc u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .pt_valid_i(pvld), .pt_last_i(plast), .pt_u_i(pu), .pt_v_i(pv),
    .pt_d_i(pd), .done_o(done), .sums_o(sums)
  );

  function automatic longint wexp(int d);
    int dd;
    dd = (d == 0) ? 1 : d;
    return longint'(256 / (dd * dd));
  endfunction

  task automatic model_add(int u, int v, int d);
    longint w;
    longint uu, vv;
    w = wexp(d); uu = longint'(u); vv = longint'(v);
    rexp[0] += w;
    rexp[1] += w * uu;
    rexp[2] += w * vv;
    rexp[3] += w * uu * uu;
    rexp[4] += w * uu * vv;
    rexp[5] += w * vv * vv;
    if (!bmode) begin
      rexp[6] += w * uu * uu * uu;
      rexp[7] += w * uu * uu * vv;
      rexp[8] += w * uu * vv * vv;
      rexp[9] += w * vv * vv * vv;
    end
  endtask

  // present one point (inputs change on the falling edge)
  task automatic push(logic st, logic md, int u, int v, int d, logic last);
    @(negedge clk);
    start = st; mode = md; pvld = 1'b1; plast = last;
    pu = 8'(u); pv = 8'(v); pd = 4'(d);
    if (st) begin
      foreach (rexp[i]) rexp[i] = 0;
      bmode = md; bopen = 1'b1;
    end
    if (bopen) begin
      model_add(u, v, d);
      if (last) bopen = 1'b0;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    start = 1'b0; pvld = 1'b0; plast = 1'b0;
  endtask

  task automatic check_done(logic exp, string req);
    tests++;
    if (done !== exp) begin
      fails++;
      $display("FAIL %s done_o: actual %0b expected %0b", req, done, exp);
    end
  endtask

  task automatic check_sums(string req);
    tests++;
    for (int i = 0; i < NM; i++) begin
      longint act;
      act = longint'($signed(sums[i]));
      if (act != rexp[i]) begin
        fails++;
        $display("FAIL %s slot %0d: actual %0d expected %0d", req, i, act, rexp[i]);
        break;
      end
    end
  endtask

  task automatic t_reset();
    foreach (rexp[i]) rexp[i] = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_done(1'b0, "R1");
    check_sums("R1");
  endtask

  task automatic t_circle();
    push(1'b1, 1'b0, 10, -3, 2, 1'b0);
    push(1'b0, 1'b0, -7, 12, 5, 1'b0);
    check_done(1'b0, "R6");
    push(1'b0, 1'b0, 100, 50, 1, 1'b0);
    push(1'b0, 1'b0, -20, -90, 9, 1'b1);
    idle();
    check_done(1'b1, "R6");
    check_sums("R4");
    idle();
    check_done(1'b0, "R6");
    check_sums("R6");
  endtask

  task automatic t_line();
    push(1'b1, 1'b1, 30, -40, 3, 1'b0);
    push(1'b0, 1'b1, -5, 66, 0, 1'b0);
    push(1'b0, 1'b1, 127, -128, 15, 1'b1);
    idle();
    check_done(1'b1, "R5");
    check_sums("R5");
  endtask

  task automatic t_weights();
    for (int d = 0; d < 16; d++) begin
      push(1'b1, 1'b0, 1, 0, d, 1'b1);
      idle();
      tests++;
      if (longint'($signed(sums[0])) != wexp(d)) begin
        fails++;
        $display("FAIL R3 weight d=%0d: actual %0d expected %0d",
                 d, longint'($signed(sums[0])), wexp(d));
      end
    end
  endtask

  task automatic t_single_point_start();
    push(1'b1, 1'b0, -9, 4, 4, 1'b1);
    idle();
    check_done(1'b1, "R2");
    check_sums("R2");
  endtask

  task automatic t_idle_ignored();
    push(1'b1, 1'b0, 3, 3, 1, 1'b1);
    idle();
    push(1'b0, 1'b0, 55, -55, 1, 1'b0);
    idle();
    check_done(1'b0, "R7");
    check_sums("R7");
    push(1'b0, 1'b0, 1, 1, 1, 1'b1);
    idle();
    check_done(1'b0, "R7");
    check_sums("R7");
  endtask

  task automatic t_mode_change();
    push(1'b1, 1'b0, 11, 22, 2, 1'b0);
    push(1'b0, 1'b1, -33, 44, 3, 1'b0);
    push(1'b0, 1'b1, 5, -6, 1, 1'b1);
    idle();
    check_sums("R8");
    push(1'b1, 1'b1, 7, 8, 2, 1'b0);
    push(1'b0, 1'b0, 9, -10, 2, 1'b1);
    idle();
    check_sums("R8");
  endtask

  task automatic t_full_scale();
    for (int n = 0; n < 64; n++)
      push(n == 0, 1'b0, -128, -128, 0, n == 63);
    idle();
    check_done(1'b1, "R9");
    check_sums("R9");
    tests++;
    if (longint'($signed(sums[6])) != -64'sd34359738368) begin
      fails++;
      $display("FAIL R9 slot 6: actual %0d expected -34359738368",
               longint'($signed(sums[6])));
    end
  endtask

  initial begin
    t_reset();
    t_circle();
    t_line();
    t_weights();
    t_single_point_start();
    t_idle_ignored();
    t_mode_change();
    t_full_scale();
    repeat (2) idle();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule